// File: doc/BRIEF.md
# Address Adder with Page-Cross Fixup

This block is the effective-address and branch-target datapath of a small 8-bit processor. A single byte-wide adder computes the low byte of an indexed address or a branch target. The sequencer looks at the adder's carry output at the end of that cycle. When the page boundary has been crossed, it spends one more cycle on the same adder to step the high byte up or down by one. Zero-page style modes wrap inside their page and never take the extra cycle.

The same adder also runs add-with-carry and subtract-with-carry. A small shifter next to it runs rotate-left and rotate-right through carry. Only these four operations read and write the architectural carry flag. Address and branch computations still produce an adder carry-out, but it only steers the sequencer and never reaches the flag.

A request is made by raising `start` while the block is idle. The block captures the base address, the operand byte and the mode on that edge. It pulses `done` when the 16-bit `result` is ready.

Top module: `addr_fixup_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `done`, `fixupUsed` and `carryFlag` are 0 and `result` is 0x0000.
- R2: `start` is sampled only when the block is idle. Inputs are captured on that edge, and `start` or input changes during a busy operation are ignored. `done` is high for exactly one cycle. It rises one clock edge after the sampling edge when no fixup runs, and two edges after when a fixup runs. Counting the sampling cycle, the result takes two cycles without a fixup and three with one.
- R3: Modes 0, 1 and 2 (unsigned indexed) give `result` = (baseAddr + operand) mod 65536. A fixup runs exactly when baseAddr[7:0] + operand > 255.
- R4: Modes 3, 4 and 5 (in-page indexed) give `result` = {baseAddr[15:8], (baseAddr[7:0] + operand) mod 256} and never run a fixup.
- R5: Mode 6 (branch) gives `result` = (baseAddr + sign-extended operand) mod 65536. A single fixup cycle runs exactly when the high byte changes, which is an increment for a positive offset and a decrement for a negative one.
- R6: Mode 7 (add with carry) gives `result` = {0x00, (baseAddr[7:0] + operand + carryFlag) mod 256}. `carryFlag` becomes bit 8 of that sum.
- R7: Mode 8 (subtract with carry) gives `result` = {0x00, (baseAddr[7:0] + ~operand + carryFlag) mod 256}. `carryFlag` becomes bit 8 of that sum, so it is 1 when no borrow occurred.
- R8: Mode 9 rotates baseAddr[7:0] left through the flag: result[7:0] = {b[6:0], carryFlag}, and the new flag is b[7]. Mode 10 rotates right: result[7:0] = {carryFlag, b[7:1]}, and the new flag is b[0]. In both modes result[15:8] is 0x00.
- R9: Modes 0 to 6 leave `carryFlag` unchanged, whatever the adder's carry output was.
- R10: `fixupUsed` is updated when `done` rises. It then shows whether the finished operation took the extra cycle, and it holds that value until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request, sampled while idle |
| mode | input | 4 | Operation select, codes 0 to 10 as in the requirements |
| baseAddr | input | 16 | Base address or program counter; bits 7:0 are the accumulator for arithmetic and rotates |
| operand | input | 8 | Index, signed branch offset, or second arithmetic operand |
| result | output | 16 | Computed address or arithmetic result, valid while done is high |
| done | output | 1 | One-cycle completion strobe |
| fixupUsed | output | 1 | High-byte fixup taken by the last completed operation |
| carryFlag | output | 1 | Architectural carry flag |

## Verification
The indexed modes are driven with low-byte sums of exactly 255 and 256, and with a base of 0xFFFF. These sums separate page-cross detection from an off-by-one compare, and the 0xFFFF base shows that the high-byte step wraps at 16 bits. The in-page modes use sums that overflow the byte, which shows whether the carry wraps inside the page or leaks into the high byte. Branches use offsets of +127, -128, -1, +1 and -2 around page edges, which separate the increment, decrement and no-fixup paths. Arithmetic and rotates run with the flag both clear and set, and address operations run right after the flag was set. Together these show whether the flag feeds carry-in and whether address work disturbs it.

// File: rtl/addr_fixup_pkg.sv
package addr_fixup_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_ABS_X   = 4'd0,
    MODE_ABS_Y   = 4'd1,
    MODE_IND_Y   = 4'd2,
    MODE_ZP_X    = 4'd3,
    MODE_ZP_Y    = 4'd4,
    MODE_ZP_IND  = 4'd5,
    MODE_BRANCH  = 4'd6,
    MODE_ADC     = 4'd7,
    MODE_SBC     = 4'd8,
    MODE_ROL     = 4'd9,
    MODE_ROR     = 4'd10
  } addrMode_e;

  // adder A-side source
  typedef enum logic [1:0] {A_OPER, A_INV, A_ZERO, A_ONES} aSel_e;
  // adder B-side source
  typedef enum logic {B_LOW, B_HIGH} bSel_e;
  // adder carry-in source
  typedef enum logic [1:0] {C_ZERO, C_ONE, C_FLAG} cinSel_e;
  // byte result source
  typedef enum logic [1:0] {O_SUM, O_ROL, O_ROR} outSel_e;

  typedef struct packed {
    logic    capture;
    aSel_e   aSel;
    bSel_e   bSel;
    cinSel_e cinSel;
    outSel_e outSel;
    logic    loadLow;
    logic    clearHigh;
    logic    loadHigh;
    logic    loadFlag;
  } dpCtrl_t;

endpackage

// File: rtl/addr_fixup_adder.sv
module addr_fixup_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
  end

endmodule

// File: rtl/addr_fixup_dp.sv
module addr_fixup_dp
  import addr_fixup_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int AW = 2 * BW
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrl_t       ctrl,
  input  logic [AW-1:0] baseAddr,
  input  logic [BW-1:0] operand,
  output logic          aluCarry,
  output logic [AW-1:0] result,
  output logic          carryFlag
);

  logic [AW-1:0] baseReg;
  logic [BW-1:0] opReg;
  logic [BW-1:0] lowReg;
  logic [BW-1:0] highReg;
  logic          flagReg;

  logic [BW-1:0] baseLow;
  logic [BW-1:0] baseHigh;
  logic [BW-1:0] addA;
  logic [BW-1:0] addB;
  logic          addCin;
  logic [BW-1:0] addSum;
  logic          addCout;
  logic [BW-1:0] outByte;
  logic          outCarry;

  assign baseLow  = baseReg[BW-1:0];
  assign baseHigh = baseReg[AW-1:BW];

  always_comb begin
    unique case (ctrl.aSel)
      A_OPER:  addA = opReg;
      A_INV:   addA = ~opReg;
      A_ZERO:  addA = '0;
      default: addA = '1;
    endcase
    addB = (ctrl.bSel == B_HIGH) ? baseHigh : baseLow;
    unique case (ctrl.cinSel)
      C_ONE:   addCin = 1'b1;
      C_FLAG:  addCin = flagReg;
      default: addCin = 1'b0;
    endcase
  end

  addr_fixup_adder #(.W(BW)) adder_i (
    .a   (addA),
    .b   (addB),
    .cin (addCin),
    .sum (addSum),
    .cout(addCout)
  );

  always_comb begin
    unique case (ctrl.outSel)
      O_ROL: begin
        outByte  = {baseLow[BW-2:0], flagReg};
        outCarry = baseLow[BW-1];
      end
      O_ROR: begin
        outByte  = {flagReg, baseLow[BW-1:1]};
        outCarry = baseLow[0];
      end
      default: begin
        outByte  = addSum;
        outCarry = addCout;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0;
      opReg   <= '0;
      lowReg  <= '0;
      highReg <= '0;
      flagReg <= 1'b0;
    end else begin
      if (ctrl.capture) begin
        baseReg <= baseAddr;
        opReg   <= operand;
      end
      if (ctrl.loadLow) begin
        lowReg  <= outByte;
        highReg <= ctrl.clearHigh ? '0 : baseHigh;
      end
      if (ctrl.loadHigh) begin
        highReg <= addSum;
      end
      if (ctrl.loadFlag) begin
        flagReg <= outCarry;
      end
    end
  end

  assign aluCarry  = addCout;
  assign result    = {highReg, lowReg};
  assign carryFlag = flagReg;

  // R3 / R5: a fixup cycle moves the high byte by exactly one step
  assert_high_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadHigh |=> ((highReg - $past(baseHigh)) == BW'(1)) ||
                      ((highReg - $past(baseHigh)) == {BW{1'b1}}));

  // low and high loads never share a cycle (R2 sequencing)
  assert_split_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.loadLow && ctrl.loadHigh));

endmodule

// File: rtl/addr_fixup_ctl.sv
module addr_fixup_ctl
  import addr_fixup_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic              offsetSign,
  input  logic              aluCarry,
  output dpCtrl_t           ctrl,
  output logic              done,
  output logic              fixupUsed
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_FIX} state_e;

  state_e            state;
  state_e            nextState;
  logic [MODE_W-1:0] modeReg;
  logic              signReg;
  logic              decReg;
  logic              fixDec;
  logic              finishNow;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    fixDec    = 1'b0;
    finishNow = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.capture = 1'b1;
          nextState    = ST_LOW;
        end
      end
      ST_LOW: begin
        ctrl.loadLow = 1'b1;
        ctrl.bSel    = B_LOW;
        ctrl.aSel    = A_OPER;
        ctrl.cinSel  = C_ZERO;
        ctrl.outSel  = O_SUM;
        nextState    = ST_IDLE;
        finishNow    = 1'b1;
        case (modeReg)
          MODE_ABS_X, MODE_ABS_Y, MODE_IND_Y: begin
            if (aluCarry) begin
              nextState = ST_FIX;
              finishNow = 1'b0;
            end
          end
          MODE_BRANCH: begin
            fixDec = signReg;
            // negative offset: no carry means the low byte went below zero
            if (signReg ? !aluCarry : aluCarry) begin
              nextState = ST_FIX;
              finishNow = 1'b0;
            end
          end
          MODE_ADC: begin
            ctrl.cinSel    = C_FLAG;
            ctrl.loadFlag  = 1'b1;
            ctrl.clearHigh = 1'b1;
          end
          MODE_SBC: begin
            ctrl.aSel      = A_INV;
            ctrl.cinSel    = C_FLAG;
            ctrl.loadFlag  = 1'b1;
            ctrl.clearHigh = 1'b1;
          end
          MODE_ROL: begin
            ctrl.outSel    = O_ROL;
            ctrl.loadFlag  = 1'b1;
            ctrl.clearHigh = 1'b1;
          end
          MODE_ROR: begin
            ctrl.outSel    = O_ROR;
            ctrl.loadFlag  = 1'b1;
            ctrl.clearHigh = 1'b1;
          end
          default: begin
            // in-page modes: the low byte simply wraps
          end
        endcase
      end
      default: begin
        ctrl.loadHigh = 1'b1;
        ctrl.bSel     = B_HIGH;
        ctrl.aSel     = decReg ? A_ONES : A_ZERO;
        ctrl.cinSel   = decReg ? C_ZERO : C_ONE;
        ctrl.outSel   = O_SUM;
        nextState     = ST_IDLE;
        finishNow     = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      modeReg   <= '0;
      signReg   <= 1'b0;
      decReg    <= 1'b0;
      done      <= 1'b0;
      fixupUsed <= 1'b0;
    end else begin
      state <= nextState;
      done  <= finishNow;
      if (ctrl.capture) begin
        modeReg <= mode;
        signReg <= offsetSign;
      end
      if (state == ST_LOW) begin
        decReg <= fixDec;
      end
      if (finishNow) begin
        fixupUsed <= (state == ST_FIX);
      end
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_fix_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIX) |=> (state == ST_IDLE) && done);

  // R4 / R10: only page-crossing modes ever report a fixup
  assert_wrap_no_fix_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && fixupUsed) |->
      (modeReg inside {MODE_ABS_X, MODE_ABS_Y, MODE_IND_Y, MODE_BRANCH}));

  assert_busy_ignores_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !ctrl.capture);

endmodule

// File: rtl/addr_fixup_unit.sv
module addr_fixup_unit
  import addr_fixup_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int AW = 2 * BW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     baseAddr,
  input  logic [BW-1:0]     operand,
  output logic [AW-1:0]     result,
  output logic              done,
  output logic              fixupUsed,
  output logic              carryFlag
);

  dpCtrl_t ctrlBus;
  logic    aluCarry;

  addr_fixup_ctl ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .mode      (mode),
    .offsetSign(operand[BW-1]),
    .aluCarry  (aluCarry),
    .ctrl      (ctrlBus),
    .done      (done),
    .fixupUsed (fixupUsed)
  );

  addr_fixup_dp #(.BW(BW)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrlBus),
    .baseAddr (baseAddr),
    .operand  (operand),
    .aluCarry (aluCarry),
    .result   (result),
    .carryFlag(carryFlag)
  );

  // R9: flag moves only on cycles the sequencer marks as arithmetic/rotate
  assert_flag_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBus.loadFlag |=> $stable(carryFlag));

endmodule

// File: tb/addr_fixup_unit_tb_top.sv
`timescale 1ns/1ps
module addr_fixup_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] baseAddr = '0;
  logic [7:0]  operand = '0;
  logic [15:0] result;
  logic        done;
  logic        fixupUsed;
  logic        carryFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic modelFlag = 1'b0;

  always #2.5 clk = ~clk;

  addr_fixup_unit dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .mode     (mode),
    .baseAddr (baseAddr),
    .operand  (operand),
    .result   (result),
    .done     (done),
    .fixupUsed(fixupUsed),
    .carryFlag(carryFlag)
  );

  // stimulus table: {mode, base, operand}
  localparam int NVEC = 16;
  localparam logic [27:0] VEC [NVEC] = '{
    {4'd0, 16'h12F0, 8'h0F},
    {4'd0, 16'h12F0, 8'h10},
    {4'd1, 16'h3400, 8'h00},
    {4'd1, 16'h34FF, 8'hFF},
    {4'd2, 16'hFFFF, 8'h01},
    {4'd2, 16'h2080, 8'h7F},
    {4'd3, 16'h00F0, 8'h20},
    {4'd4, 16'h00FF, 8'h01},
    {4'd5, 16'h0080, 8'h80},
    {4'd6, 16'h1080, 8'h7F},
    {4'd6, 16'h1081, 8'h7F},
    {4'd6, 16'h1080, 8'h80},
    {4'd6, 16'h107F, 8'h80},
    {4'd6, 16'h1000, 8'hFF},
    {4'd6, 16'h10FF, 8'h01},
    {4'd6, 16'h0000, 8'hFE}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string modeTag(input logic [3:0] m);
    if (m <= 4'd2) return "R3";
    if (m <= 4'd5) return "R4";
    if (m == 4'd6) return "R5";
    if (m == 4'd7) return "R6";
    if (m == 4'd8) return "R7";
    return "R8";
  endfunction

  task automatic runOp(input logic [3:0] m, input logic [15:0] b, input logic [7:0] o);
    logic [15:0] expRes;
    logic        expFix;
    logic        expFlag;
    logic [8:0]  t;
    int          lat;
    expFlag = modelFlag;
    expFix  = 1'b0;
    case (m)
      4'd0, 4'd1, 4'd2: begin
        expRes = b + {8'h00, o};
        expFix = (expRes[15:8] != b[15:8]);
      end
      4'd6: begin
        expRes = b + {{8{o[7]}}, o};
        expFix = (expRes[15:8] != b[15:8]);
      end
      4'd7: begin
        t = {1'b0, b[7:0]} + {1'b0, o} + {8'h00, modelFlag};
        expRes = {8'h00, t[7:0]};
        expFlag = t[8];
      end
      4'd8: begin
        t = {1'b0, b[7:0]} + {1'b0, ~o} + {8'h00, modelFlag};
        expRes = {8'h00, t[7:0]};
        expFlag = t[8];
      end
      4'd9: begin
        expRes = {8'h00, b[6:0], modelFlag};
        expFlag = b[7];
      end
      4'd10: begin
        expRes = {8'h00, modelFlag, b[7:1]};
        expFlag = b[0];
      end
      default: begin
        expRes = {b[15:8], b[7:0] + o};
      end
    endcase
    @(negedge clk);
    start = 1'b1; mode = m; baseAddr = b; operand = o;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check({modeTag(m), " result"}, result, expRes);
    check("R2 latency", lat, expFix ? 3 : 2);
    check("R10 fixupUsed", fixupUsed, expFix);
    check((m <= 4'd6) ? "R9 flag kept" : {modeTag(m), " flag"}, carryFlag, expFlag);
    modelFlag = expFlag;
    @(negedge clk);
    check("R2 done pulse", done, 1'b0);
    check("R10 fixupUsed hold", fixupUsed, expFix);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check("R1 done in reset", done, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 done", done, 1'b0);
    check("R1 result", result, 16'h0000);
    check("R1 fixupUsed", fixupUsed, 1'b0);
    check("R1 carryFlag", carryFlag, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      runOp(VEC[i][27:24], VEC[i][23:8], VEC[i][7:0]);
    end

    // arithmetic and rotates with flag clear and set (R6 R7 R8)
    runOp(4'd7, 16'h00FF, 8'h01);
    runOp(4'd7, 16'h5510, 8'h20);
    runOp(4'd7, 16'h0080, 8'h80);
    // flag is 1 here: address work must keep it (R9)
    runOp(4'd0, 16'h12F0, 8'h10);
    runOp(4'd6, 16'h107F, 8'h80);
    check("R9 flag still set", carryFlag, 1'b1);
    runOp(4'd8, 16'h0050, 8'h10);
    runOp(4'd8, 16'h0010, 8'h20);
    runOp(4'd8, 16'h0010, 8'h05);
    runOp(4'd9, 16'h0081, 8'h00);
    runOp(4'd10, 16'h0001, 8'h00);
    runOp(4'd10, 16'h0002, 8'h00);
    runOp(4'd9, 16'h0040, 8'h00);

    // R2: start held and inputs changed while busy are ignored
    @(negedge clk);
    start = 1'b1; mode = 4'd0; baseAddr = 16'h12F0; operand = 8'h10;
    @(posedge clk);
    @(negedge clk);
    baseAddr = 16'hAAAA; operand = 8'h55; mode = 4'd6;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    repeat (6) begin
      @(negedge clk);
      if (done) begin
        cnt++;
        check("R2 captured result", result, 16'h1300);
        check("R10 busy fixup", fixupUsed, 1'b1);
      end
    end
    check("R2 single done while busy", cnt, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule